// File: doc/BRIEF.md
# SD Host Vendor Register Bank

This block is the vendor-specific register front of an SD/eMMC host controller. It decodes a 4 KB window of 32-bit words on a simple request bus (valid, write flag, byte address, write data) and returns read data one cycle after the request. The lower 512 bytes hold a local bank of 128 words. Everything from byte 0x200 upward is forwarded, rebased to zero, to a standard host register block on a pass-through port. The interrupt of that block becomes the interrupt of the whole controller.

Three local words have write side effects. The control word at byte 0x00 ignores stored data. Its bit 0 acts as a soft reset that restores the whole local bank and pulses a reset toward the standard block. The PHY-access word at 0x10 derives its acknowledge bit from two request bits. The tuning word at 0x18 never keeps its tune-request bit set.

Top module: `sdhost_vendor_bank`

## Requirements
- R1: After rst_ni is released, every local word reads 0, except the word at byte 0x00, which reads 0x00010000.
- R2: A write to any local word other than 0x00, 0x10 and 0x18 stores the 32-bit data unchanged. A read of a local word returns the stored value on rsp_rdata_o in the cycle after the request. The word index is address bits [8:2].
- R3: A write to 0x10 with bit 24 (write request) or bit 25 (read request) set stores the data with bit 26 (acknowledge) forced to 1.
- R4: A write to 0x10 with bits 24 and 25 both clear stores the data with bit 26 forced to 0.
- R5: A write to 0x18 stores bit 15 (tune request) as 0 and all other bits as written.
- R6: A write to 0x00 with bit 0 set returns all 128 local words to their R1 values. In the cycle after that write, std_rst_o is 1 for exactly one cycle.
- R7: A write to 0x00 with bit 0 clear has no effect. The word keeps reading 0x00010000, and std_rst_o stays 0.
- R8: A request at byte 0x200 or above drives std_valid_o, with std_write_o and std_wdata_o taken from the request and std_addr_o equal to address minus 0x200. Its read data is std_rdata_i in the following cycle. It does not change any local word.
- R9: A local request never asserts std_valid_o.
- R10: irq_o follows std_irq_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address in the window |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid the cycle after a read |
| std_valid_o | output | 1 | Forwarded request valid |
| std_write_o | output | 1 | Forwarded write flag |
| std_addr_o | output | 12 | Forwarded byte offset (address − 0x200) |
| std_wdata_o | output | 32 | Forwarded write data |
| std_rdata_i | input | 32 | Read data from the standard block, one cycle after its request |
| std_rst_o | output | 1 | One-cycle reset pulse toward the standard block |
| std_irq_i | input | 1 | Interrupt from the standard block |
| irq_o | output | 1 | Controller interrupt |

## Verification
The hardest case to reach is a soft reset that arrives while the whole bank holds non-default data. To build it, the bench first fills every one of the 128 words with its own pattern, including an acknowledge set at 0x10. It then issues the soft-reset write and reads back every word against the reference array. A control write with bit 0 clear is sent between the fill and the soft reset, to show that the control word cannot be disturbed. Forwarded traffic is interleaved with local traffic so that the response select is tested in both directions.

// File: rtl/sdvb_pkg.sv
package sdvb_pkg;
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_PHY    = 4;
  localparam int unsigned IDX_TUNE   = 6;
  localparam logic [31:0] CTRL_POR   = 32'h0001_0000;
  localparam int unsigned SRST_BIT   = 0;
  localparam int unsigned PHY_WREQ   = 24;
  localparam int unsigned PHY_RREQ   = 25;
  localparam int unsigned PHY_ACK    = 26;
  localparam int unsigned TUNE_BIT   = 15;
endpackage

// File: rtl/sdvb_decode.sv
module sdvb_decode #(
  parameter int unsigned AW          = 12,
  parameter int unsigned LOCAL_BYTES = 512,
  parameter int unsigned IW          = 7
) (
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  output logic          loc_wr_o,
  output logic          loc_rd_o,
  output logic          std_hit_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] std_off_o
);
  logic is_local;

  assign is_local  = addr_i < AW'(LOCAL_BYTES);
  assign loc_wr_o  = valid_i &&  is_local &&  write_i;
  assign loc_rd_o  = valid_i &&  is_local && !write_i;
  assign std_hit_o = valid_i && !is_local;
  assign idx_o     = addr_i[IW+1:2];
  assign std_off_o = addr_i - AW'(LOCAL_BYTES);
endmodule

// File: rtl/sdvb_wshape.sv
module sdvb_wshape
  import sdvb_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 7
) (
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic          we_o,
  output logic [DW-1:0] wval_o,
  output logic          soft_rst_o
);
  always_comb begin
    we_o       = wr_i;
    wval_o     = wdata_i;
    soft_rst_o = 1'b0;
    if (idx_i == IW'(IDX_CTRL)) begin
      // control word holds no data; only the reset trigger matters
      we_o       = 1'b0;
      soft_rst_o = wr_i && wdata_i[SRST_BIT];
    end else if (idx_i == IW'(IDX_PHY)) begin
      wval_o[PHY_ACK] = wdata_i[PHY_WREQ] | wdata_i[PHY_RREQ];
    end else if (idx_i == IW'(IDX_TUNE)) begin
      wval_o[TUNE_BIT] = 1'b0;
    end
  end
endmodule

// File: rtl/sdvb_regfile.sv
module sdvb_regfile
  import sdvb_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 128,
  parameter int unsigned IW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wval_i,
  input  logic          soft_rst_i,
  input  logic          re_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [DW-1:0] RV = (g == IDX_CTRL) ? DW'(CTRL_POR) : '0;
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        word_q <= RV;
      else if (soft_rst_i)                word_q <= RV;
      else if (we_i && widx_i == IW'(g))  word_q <= wval_i;
    end
    assign mem[g] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[ridx_i];
  end

  // R3 R4
  ack_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem[IDX_PHY][PHY_ACK] == (mem[IDX_PHY][PHY_WREQ] | mem[IDX_PHY][PHY_RREQ]));

  // R5
  tune_never_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem[IDX_TUNE][TUNE_BIT] == 1'b0);

  // R6
  soft_rst_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (mem[IDX_CTRL] == DW'(CTRL_POR)) && (mem[IDX_PHY] == '0));

  // R7
  ctrl_word_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> $stable(mem[IDX_CTRL]));
endmodule

// File: rtl/sdhost_vendor_bank.sv
module sdhost_vendor_bank #(
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 32,
  parameter int unsigned LOCAL_BYTES = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          std_valid_o,
  output logic          std_write_o,
  output logic [AW-1:0] std_addr_o,
  output logic [DW-1:0] std_wdata_o,
  input  logic [DW-1:0] std_rdata_i,
  output logic          std_rst_o,
  input  logic          std_irq_i,
  output logic          irq_o
);
  localparam int unsigned WORDS = LOCAL_BYTES / 4;
  localparam int unsigned IW    = $clog2(WORDS);

  logic          loc_wr, loc_rd, std_hit, we, soft_rst;
  logic [IW-1:0] idx;
  logic [DW-1:0] wval, loc_rdata;
  logic          sel_std_q, rst_pulse_q;

  sdvb_decode #(.AW(AW), .LOCAL_BYTES(LOCAL_BYTES), .IW(IW)) u_decode (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .loc_wr_o (loc_wr),
    .loc_rd_o (loc_rd),
    .std_hit_o(std_hit),
    .idx_o    (idx),
    .std_off_o(std_addr_o)
  );

  sdvb_wshape #(.DW(DW), .IW(IW)) u_wshape (
    .wr_i      (loc_wr),
    .idx_i     (idx),
    .wdata_i   (req_wdata_i),
    .we_o      (we),
    .wval_o    (wval),
    .soft_rst_o(soft_rst)
  );

  sdvb_regfile #(.DW(DW), .WORDS(WORDS), .IW(IW)) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .widx_i    (idx),
    .wval_i    (wval),
    .soft_rst_i(soft_rst),
    .re_i      (loc_rd),
    .ridx_i    (idx),
    .rdata_o   (loc_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_std_q   <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      if (req_valid_i) sel_std_q <= std_hit;
      rst_pulse_q <= soft_rst;
    end
  end

  assign std_valid_o = std_hit;
  assign std_write_o = req_write_i;
  assign std_wdata_o = req_wdata_i;
  assign std_rst_o   = rst_pulse_q;
  assign rsp_rdata_o = sel_std_q ? std_rdata_i : loc_rdata;
  assign irq_o       = std_irq_i;

  // R6
  rst_pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    std_rst_o |-> $past(soft_rst));

  // R9
  local_not_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_wr || loc_rd) |-> !std_valid_o);
endmodule

// File: tb/sdhost_vendor_bank_tb.sv
module sdhost_vendor_bank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rsp_rdata_o;
  logic        std_valid_o, std_write_o, std_rst_o, irq_o;
  logic [11:0] std_addr_o;
  logic [31:0] std_wdata_o;
  logic [31:0] std_rdata_i = '0;
  logic        std_irq_i = 1'b0;

  int nvec = 0, nerr = 0;
  logic [31:0] model [128];
  logic [31:0] dmem [16];

  always #2 clk = ~clk;

  sdhost_vendor_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_rdata_o(rsp_rdata_o),
    .std_valid_o(std_valid_o), .std_write_o(std_write_o),
    .std_addr_o(std_addr_o), .std_wdata_o(std_wdata_o),
    .std_rdata_i(std_rdata_i), .std_rst_o(std_rst_o),
    .std_irq_i(std_irq_i), .irq_o(irq_o)
  );

  // downstream standard block model
  always @(posedge clk) if (std_valid_o) begin
    if (std_write_o) dmem[std_addr_o[5:2]] <= std_wdata_o;
    std_rdata_i <= dmem[std_addr_o[5:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model_por();
    for (int i = 0; i < 128; i++) model[i] = (i == 0) ? 32'h0001_0000 : 32'h0;
  endfunction

  function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
    int i = int'(a[8:2]);
    logic [31:0] v = d;
    if (i == 0) begin
      if (d[0]) model_por();
      return;
    end
    if (i == 4) v[26] = d[24] | d[25];
    if (i == 6) v[15] = 1'b0;
    model[i] = v;
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    #1;
    if (a < 12'h200) chk("R9", 32'(std_valid_o), 32'h0);
    @(negedge clk);
    req_valid_i = 0; req_write_i = 0;
    if (a < 12'h200) model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    #1;
    if (a < 12'h200) chk("R9", 32'(std_valid_o), 32'h0);
    @(negedge clk);
    req_valid_i = 0;
    d = rsp_rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, model[a[8:2]]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 128; i++) rd_chk("R1", 12'(i * 4));
    chk("R6", 32'(std_rst_o), 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] p = 32'hA5C3_1E07;
    for (int i = 1; i < 128; i++) begin
      p = {p[30:0], p[31] ^ p[21] ^ p[1] ^ p[0]};
      bus_wr(12'(i * 4), p ^ 32'(i));
    end
    for (int i = 1; i < 128; i++) rd_chk("R2", 12'(i * 4));
    bus_wr(12'h02B, 32'h1234_5678);  // low address bits ignored -> word 10
    rd_chk("R2", 12'h028);
  endtask

  task automatic t_ack();
    bus_wr(12'h010, 32'h0100_00FF); rd_chk("R3", 12'h010);
    bus_wr(12'h010, 32'h0200_0001); rd_chk("R3", 12'h010);
    bus_wr(12'h010, 32'h0300_0000); rd_chk("R3", 12'h010);
    bus_wr(12'h010, 32'h0400_1234); rd_chk("R4", 12'h010);
    bus_wr(12'h010, 32'hF8FF_FFFF); rd_chk("R4", 12'h010);
    bus_wr(12'h010, 32'h0500_0000); rd_chk("R3", 12'h010);
  endtask

  task automatic t_tune();
    bus_wr(12'h018, 32'hFFFF_FFFF); rd_chk("R5", 12'h018);
    bus_wr(12'h018, 32'h0000_8001); rd_chk("R5", 12'h018);
    bus_wr(12'h018, 32'h1234_0000); rd_chk("R5", 12'h018);
  endtask

  task automatic t_ctrl_ignore();
    bus_wr(12'h000, 32'hFFFF_FFFE);
    chk("R7", 32'(std_rst_o), 32'h0);
    rd_chk("R7", 12'h000);
    rd_chk("R7", 12'h010);
  endtask

  task automatic t_soft();
    bus_wr(12'h000, 32'h0000_0001);
    chk("R6", 32'(std_rst_o), 32'h1);
    @(negedge clk);
    chk("R6", 32'(std_rst_o), 32'h0);
    for (int i = 0; i < 128; i++) rd_chk("R6", 12'(i * 4));
  endtask

  task automatic t_passthru();
    logic [31:0] d;
    bus_wr(12'h010, 32'h0100_0000);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 1; req_addr_i = 12'h208; req_wdata_i = 32'hCAFE_F00D;
    #1;
    chk("R8", 32'(std_valid_o), 32'h1);
    chk("R8", 32'(std_addr_o), 32'h008);
    chk("R8", std_wdata_o, 32'hCAFE_F00D);
    chk("R8", 32'(std_write_o), 32'h1);
    @(negedge clk);
    req_valid_i = 0; req_write_i = 0;
    bus_wr(12'hE3C, 32'h0BAD_BEEF);
    bus_rd(12'h208, d);
    chk("R8", d, 32'hCAFE_F00D);
    rd_chk("R8", 12'h008);          // local word 2 untouched
    bus_rd(12'hE3C, d);
    chk("R8", d, 32'h0BAD_BEEF);
    rd_chk("R8", 12'h010);          // local follows forwarded read
    @(negedge clk);
    req_valid_i = 1; req_addr_i = 12'hFFC;
    #1;
    chk("R8", 32'(std_addr_o), 32'hDFC);
    @(negedge clk);
    req_valid_i = 0;
  endtask

  task automatic t_irq();
    std_irq_i = 1; #1; chk("R10", 32'(irq_o), 32'h1);
    std_irq_i = 0; #1; chk("R10", 32'(irq_o), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    model_por();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_plain();
    t_ack();
    t_tune();
    t_ctrl_ignore();
    t_soft();
    t_passthru();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule